// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers 32 level-sensitive request lines and drives two processor inputs: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Software reaches it through a simple register port. Through that port it can do the following:

- enable or disable each line;
- mark each line as normal or fast type;
- raise a software request on the spare line;
- read the raw and masked status;
- program sixteen vector slots, each bound to one line and holding a handler address.

A normal-type request that belongs to an enabled slot is vectored. Reading the vector register returns the handler address of the best slot that is pending and not masked. That read also records the slot as in service, so requests at the same or a lower rank stop signalling `irq_o` until software writes the vector register to close the service. A request from a higher-ranked slot can still interrupt a routine already in service. Lines that no enabled slot claims are served through a programmable default address. Fast-type lines skip the vector logic and are ORed together onto `fiq_o`.

Register map (word address on `addr_i`):

| Address | Access | Function |
|---|---|---|
| 0x00 | read | Raw line status |
| 0x01 | read | Masked normal status |
| 0x02 | read | Masked fast status |
| 0x03 | read | Enable register |
| 0x03 | write | Enable set |
| 0x04 | write | Enable clear |
| 0x05 | read/write | Type (1 = fast) |
| 0x06 | read/write | Software request, bit 0 |
| 0x08 | read | Vector address, pushes the in-service level |
| 0x08 | write | End of service |
| 0x09 | read/write | Default address |
| 0x10+n | read/write | Slot n control |
| 0x20+n | read/write | Slot n handler address |

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every line is disabled and of normal type, and every slot reads 0 and is disabled. The default address is 0. With all request lines high, `irq_o` and `fiq_o` are 0 and a vector read returns 0.
- R2: A write to 0x03 sets the enable bits whose `wdata_i` bit is 1. A write to 0x04 clears the enable bits whose `wdata_i` bit is 1. A read of 0x03 returns the enable register. A disabled line raises neither output.
- R3: Status reads work as follows:
  - A read of 0x00 returns `src_i`, with bit 31 additionally set while bit 0 of register 0x06 is 1 (the software request on the spare line).
  - A read of 0x01 returns the raw status AND enable AND NOT type.
  - A read of 0x02 returns the raw status AND enable AND type.
- R4: In register 0x05, a bit value of 1 makes that line fast type. `fiq_o` is 1 exactly when an enabled fast-type line is active. A fast-type line never causes `irq_o` and never selects a vector.
- R5: Slot n is configured in two registers:
  - Register 0x10+n holds the source line index in bits [4:0] and an enable in bit 5.
  - Register 0x20+n holds the 32-bit handler address.
  A vector read returns the address of the chosen slot.
- R6: Slot 0 ranks highest and slot 15 lowest. Among pending enabled slots whose source is an active, enabled, normal-type line, the lowest-numbered one that is not masked is chosen. A default-vectored request ranks below every slot.
- R7: A vector read that chooses slot k puts k in service. Slot k and every slot above k in number are then masked. `irq_o` falls if only masked or default requests remain. A pending slot numbered below k still raises `irq_o` and is returned by the next vector read.
- R8: A write of any value to 0x08 releases the most recently entered level that is still in service. The level entered before it is then in force again. A release with nothing in service has no effect.
- R9: An active, enabled, normal-type line that no enabled slot claims raises `irq_o` only while no slot is in service. If no slot can be chosen, a vector read returns the address in 0x09 and puts nothing in service.
- R10: A line bound only to a disabled slot is handled as default-vectored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive request lines |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effect at 0x08 only) |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two things can fall in the same cycle: a vector read, and a change on the request lines. The read chooses its slot from the lines as they stand in that cycle, and it pushes that slot. The bench provokes this by changing `src_i` in the same cycle as the read strobe. It expects the address of the slot that the new pattern selects. Nesting is judged by stacking two levels and releasing one. A following vector read must then return the inner slot's address again, and it would not if the wrong level had been released.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int LINES = 32;
    localparam int SLOTS = 16;
    localparam int IDX_W = 5;
    localparam int DW    = 32;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] src;
    } slot_cfg_t;

    localparam logic [7:0] A_RAW   = 8'h00;
    localparam logic [7:0] A_MIRQ  = 8'h01;
    localparam logic [7:0] A_MFIQ  = 8'h02;
    localparam logic [7:0] A_ENSET = 8'h03;
    localparam logic [7:0] A_ENCLR = 8'h04;
    localparam logic [7:0] A_TYPE  = 8'h05;
    localparam logic [7:0] A_SOFT  = 8'h06;
    localparam logic [7:0] A_VEC   = 8'h08;
    localparam logic [7:0] A_DFLT  = 8'h09;
    localparam logic [3:0] PG_SCFG = 4'h1;
    localparam logic [3:0] PG_SADR = 4'h2;

    function automatic slot_cfg_t cfg_from_word(logic [IDX_W:0] w);
        slot_cfg_t c;
        c.en  = w[IDX_W];
        c.src = w[IDX_W-1:0];
        return c;
    endfunction

    function automatic logic [DW-1:0] cfg_to_word(slot_cfg_t c);
        return DW'({c.en, c.src});
    endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
#(
    parameter int NLINES = LINES,
    parameter int NSLOTS = SLOTS
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          wr_i,
    input  logic [7:0]                    addr_i,
    input  logic [DW-1:0]                 wdata_i,
    output logic [NLINES-1:0]             en_q,
    output logic [NLINES-1:0]             typ_q,
    output logic                          soft_q,
    output logic [DW-1:0]                 dflt_q,
    output slot_cfg_t [NSLOTS-1:0]        cfg_q,
    output logic [NSLOTS-1:0][DW-1:0]     sadr_q
);
    localparam int SW = $clog2(NSLOTS);

    logic [SW-1:0] sidx;
    assign sidx = addr_i[SW-1:0];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q   <= '0;
            typ_q  <= '0;
            soft_q <= 1'b0;
            dflt_q <= '0;
            cfg_q  <= '0;
            sadr_q <= '0;
        end else if (wr_i) begin
            case (addr_i)
                A_ENSET: en_q   <= en_q | wdata_i[NLINES-1:0];
                A_ENCLR: en_q   <= en_q & ~wdata_i[NLINES-1:0];
                A_TYPE:  typ_q  <= wdata_i[NLINES-1:0];
                A_SOFT:  soft_q <= wdata_i[0];
                A_DFLT:  dflt_q <= wdata_i;
                default: begin
                    if (addr_i[7:4] == PG_SCFG)
                        cfg_q[sidx] <= cfg_from_word(wdata_i[IDX_W:0]);
                    else if (addr_i[7:4] == PG_SADR)
                        sadr_q[sidx] <= wdata_i;
                end
            endcase
        end
    end

    // R2
    enclr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && addr_i == A_ENCLR) |=> ((en_q & $past(wdata_i[NLINES-1:0])) == '0));

    // R2
    enset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && addr_i == A_ENSET) |=> ((en_q & $past(wdata_i[NLINES-1:0])) == $past(wdata_i[NLINES-1:0])));
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
#(
    parameter int NLINES = LINES,
    parameter int NSLOTS = SLOTS
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [NLINES-1:0]          act_i,
    input  slot_cfg_t [NSLOTS-1:0]     cfg_i,
    input  logic                       push_i,
    input  logic                       pop_i,
    output logic                       win_valid_o,
    output logic [$clog2(NSLOTS)-1:0]  win_idx_o,
    output logic                       dflt_req_o,
    output logic                       busy_o
);
    localparam int SW = $clog2(NSLOTS);
    localparam int LW = $clog2(NSLOTS + 1);

    logic [NLINES-1:0] bound;
    logic [NSLOTS-1:0] slot_req;
    logic [NSLOTS-1:0] win_vec;
    logic [NSLOTS-1:0] svc_q;
    logic [LW-1:0]     cur_lvl;

    always_comb begin
        bound = '0;
        for (int n = 0; n < NSLOTS; n++)
            if (cfg_i[n].en) bound[cfg_i[n].src] = 1'b1;
    end

    for (genvar n = 0; n < NSLOTS; n++) begin : g_req
        assign slot_req[n] = cfg_i[n].en & act_i[cfg_i[n].src];
    end

    always_comb begin
        cur_lvl = LW'(NSLOTS);
        for (int n = NSLOTS - 1; n >= 0; n--)
            if (svc_q[n]) cur_lvl = LW'(n);
    end

    always_comb begin
        win_vec     = '0;
        win_idx_o   = '0;
        win_valid_o = 1'b0;
        for (int n = 0; n < NSLOTS; n++) begin
            if (!win_valid_o && slot_req[n] && (LW'(n) < cur_lvl)) begin
                win_vec[n]  = 1'b1;
                win_idx_o   = SW'(n);
                win_valid_o = 1'b1;
            end
        end
    end

    assign dflt_req_o = |(act_i & ~bound);
    assign busy_o     = |svc_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            svc_q <= '0;
        else if (pop_i)
            svc_q <= svc_q & (svc_q - 1'b1);
        else if (push_i)
            svc_q <= svc_q | win_vec;
    end

    // R6
    grant_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(win_vec));

    // R7
    push_grow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (push_i && !pop_i) |=> ($countones(svc_q) == $countones($past(svc_q)) + 1));

    // R8
    pop_shrink_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_i && (|svc_q)) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));

    // R8
    pop_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pop_i && !(|svc_q)) |=> (svc_q == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NLINES = LINES,
    parameter int NSLOTS = SLOTS,
    parameter int SPARE  = LINES - 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NLINES-1:0] src_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam int SW = $clog2(NSLOTS);

    logic [NLINES-1:0]          en_q, typ_q, raw, act_irq, act_fiq;
    logic                       soft_q, win_valid, dflt_req, busy, push, pop;
    logic [DW-1:0]              dflt_q;
    slot_cfg_t [NSLOTS-1:0]     cfg_q;
    logic [NSLOTS-1:0][DW-1:0]  sadr_q;
    logic [SW-1:0]              win_idx;

    irqv_regs #(.NLINES(NLINES), .NSLOTS(NSLOTS)) u_regs (
        .clk_i(clk_i), .rst_i(rst_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .en_q(en_q), .typ_q(typ_q), .soft_q(soft_q),
        .dflt_q(dflt_q), .cfg_q(cfg_q), .sadr_q(sadr_q)
    );

    always_comb begin
        raw        = src_i;
        raw[SPARE] = src_i[SPARE] | soft_q;
    end

    assign act_irq = raw & en_q & ~typ_q;
    assign act_fiq = raw & en_q & typ_q;
    assign push    = rd_i && (addr_i == A_VEC) && win_valid;
    assign pop     = wr_i && (addr_i == A_VEC);

    irqv_prio #(.NLINES(NLINES), .NSLOTS(NSLOTS)) u_prio (
        .clk_i(clk_i), .rst_i(rst_i), .act_i(act_irq), .cfg_i(cfg_q),
        .push_i(push), .pop_i(pop), .win_valid_o(win_valid),
        .win_idx_o(win_idx), .dflt_req_o(dflt_req), .busy_o(busy)
    );

    assign irq_o = win_valid | (dflt_req & ~busy);
    assign fiq_o = |act_fiq;

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_RAW:   rdata_o = DW'(raw);
            A_MIRQ:  rdata_o = DW'(act_irq);
            A_MFIQ:  rdata_o = DW'(act_fiq);
            A_ENSET: rdata_o = DW'(en_q);
            A_TYPE:  rdata_o = DW'(typ_q);
            A_SOFT:  rdata_o = DW'(soft_q);
            A_VEC:   rdata_o = win_valid ? sadr_q[win_idx] : dflt_q;
            A_DFLT:  rdata_o = dflt_q;
            default: begin
                if (addr_i[7:4] == PG_SCFG)
                    rdata_o = cfg_to_word(cfg_q[addr_i[SW-1:0]]);
                else if (addr_i[7:4] == PG_SADR)
                    rdata_o = sadr_q[addr_i[SW-1:0]];
            end
        endcase
    end

    // R4
    fiq_no_vec_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        win_valid |-> ((act_irq & ~typ_q) != '0));

    // R9
    dflt_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy && !win_valid) |-> !irq_o);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic [31:0] src_i = '0;
    logic        wr_i = 1'b0, rd_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o, fiq_o;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl dut (
        .clk_i(clk), .rst_i(rst_i), .src_i(src_i), .wr_i(wr_i), .rd_i(rd_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    localparam logic [31:0] DFLT = 32'hDEAD_0000;
    // {src, irq, fiq, vector}
    localparam logic [65:0] TBL [8] = '{
        {32'h0000_0000,           1'b0, 1'b0, DFLT},
        {32'h0000_0020,           1'b1, 1'b0, 32'h0000_1300},
        {32'h0010_0020,           1'b1, 1'b0, 32'h0000_1000},
        {32'h0000_1000,           1'b1, 1'b0, 32'h0000_1F00},
        {32'h0000_0080,           1'b0, 1'b1, DFLT},
        {32'h0000_0004,           1'b1, 1'b0, DFLT},
        {32'h0000_1004,           1'b1, 1'b0, 32'h0000_1F00},
        {32'h4000_0000,           1'b1, 1'b0, DFLT}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk); #1;
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_i = 1'b1; addr_i = a;
        #1 d = rdata_o;
        @(posedge clk); #1;
        rd_i = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        src_i = '1;
        repeat (3) @(posedge clk);
        #1 rst_i = 1'b0;

        // R1 reset state
        @(negedge clk); #1;
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 fiq", 32'(fiq_o), 0);
        rd(8'h03, d); chk("R1 enable", d, 0);
        rd(8'h05, d); chk("R1 type", d, 0);
        rd(8'h1F, d); chk("R1 slot15", d, 0);
        rd(8'h08, d); chk("R1 vector", d, 0);
        rd(8'h00, d); chk("R3 raw", d, 32'hFFFF_FFFF);

        // R2 enable set and clear
        wr(8'h03, 32'h0000_00F0);
        wr(8'h03, 32'h0000_000F);
        rd(8'h03, d); chk("R2 set", d, 32'h0000_00FF);
        wr(8'h04, 32'h0000_003C);
        rd(8'h03, d); chk("R2 clear", d, 32'h0000_00C3);
        wr(8'h04, 32'hFFFF_FFFF);
        @(negedge clk); #1;
        chk("R2 disabled irq", 32'(irq_o), 0);

        // configuration
        wr(8'h03, 32'hFFFF_FFFF);
        wr(8'h05, 32'h0000_0080);
        wr(8'h09, DFLT);
        wr(8'h10, 32'h20 | 20); wr(8'h20, 32'h1000);
        wr(8'h13, 32'h20 | 5);  wr(8'h23, 32'h1300);
        wr(8'h19, 32'h20 | 7);  wr(8'h29, 32'h1900);
        wr(8'h1F, 32'h20 | 12); wr(8'h2F, 32'h1F00);
        wr(8'h16, 32'h00 | 2);  wr(8'h26, 32'h1600);
        rd(8'h13, d); chk("R5 slot cfg", d, 32'h25);

        // R3 masked status and software request
        set_src(32'h0000_00A0);
        rd(8'h01, d); chk("R3 masked irq", d, 32'h0000_0020);
        rd(8'h02, d); chk("R4 masked fiq", d, 32'h0000_0080);
        set_src(32'h0);
        wr(8'h06, 32'h1);
        rd(8'h00, d); chk("R3 soft raw", d, 32'h8000_0000);
        wr(8'h06, 32'h0);

        // table: R4 R5 R6 R9 R10
        foreach (TBL[i]) begin
            set_src(TBL[i][65:34]);
            chk($sformatf("R6 irq row%0d", i), 32'(irq_o), 32'(TBL[i][33]));
            chk($sformatf("R4 fiq row%0d", i), 32'(fiq_o), 32'(TBL[i][32]));
            rd(8'h08, d);
            chk($sformatf("R5 vector row%0d", i), d, TBL[i][31:0]);
            wr(8'h08, 32'h0);
        end

        // R7 nesting
        set_src(32'h0000_1000);
        rd(8'h08, d); chk("R7 first vector", d, 32'h1F00);
        @(negedge clk); #1; chk("R7 masked own", 32'(irq_o), 0);
        set_src(32'h4000_1000);
        chk("R9 default masked", 32'(irq_o), 0);
        set_src(32'h4000_1020);
        chk("R7 preempt irq", 32'(irq_o), 1);
        rd(8'h08, d); chk("R7 preempt vector", d, 32'h1300);
        @(negedge clk); #1; chk("R7 inner masked", 32'(irq_o), 0);
        rd(8'h08, d); chk("R9 default no push", d, DFLT);
        wr(8'h08, 32'h0);
        rd(8'h08, d); chk("R8 released inner", d, 32'h1300);
        wr(8'h08, 32'h0);
        wr(8'h08, 32'h0);
        @(negedge clk); #1; chk("R8 empty irq", 32'(irq_o), 1);
        wr(8'h08, 32'h0);
        set_src(32'h0000_1000);
        rd(8'h08, d); chk("R8 pop on empty", d, 32'h1F00);
        wr(8'h08, 32'h0);

        // same-cycle source change and vector read
        set_src(32'h0);
        @(negedge clk);
        src_i = 32'h0010_0000; rd_i = 1'b1; addr_i = 8'h08;
        #1 d = rdata_o;
        @(posedge clk); #1 rd_i = 1'b0;
        chk("R6 same-cycle vector", d, 32'h1000);
        @(negedge clk); #1; chk("R7 same-cycle pushed", 32'(irq_o), 0);
        wr(8'h08, 32'h0);
        @(negedge clk); #1; chk("R8 released", 32'(irq_o), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule